// File: doc/BRIEF.md
# Vending Credit Accumulator with Change Decode

This block holds the money inserted into a vending machine as a count of nickel units. An upstream coin sensor delivers one pulse per nickel. The block credits each pulse only when the pulse ends, which is its trailing edge. A parameterised product price is subtracted from the credit all the time by a chain of full-subtractor cells. When that chain produces no borrow, the release output goes high. The non-negative difference is then shown as a change code.

A vend acknowledge from the dispensing logic returns the credit to zero. The credit value is exported so that a display can show it. The change decode looks only at the low bits of the difference. It therefore stays the same if the credit width grows. Differences above five nickels cannot occur with the default price and are not decoded.

The pulse front end is a two-state machine. **PULSE_IDLE** means the registered pulse is low. Its transition *arm* (registered pulse high) leads to **PULSE_ACTIVE**. **PULSE_ACTIVE** holds while the pulse stays high. Its transition *credit* (registered pulse low) returns to PULSE_IDLE and issues a one-cycle increment strobe.

Top module: `vend_credit_unit`

## Requirements
- R1: After synchronous reset, credit_o is 0, release_o is 0 and change_o is 0.
- R2: A count pulse adds exactly one unit on its trailing edge. pulse_i is registered once. Say the first clock edge that samples pulse_i low after a high period is edge m. credit_o keeps its old value through edge m and shows the increment after edge m+1.
- R3: A pulse adds one unit however long it stays high. credit_o does not change while pulse_i is held high.
- R4: The credit saturates at 2^CREDIT_W-1 units (15 by default). Pulses counted at that value are ignored.
- R5: release_o is 1 exactly when credit_o >= PRICE_UNITS, that is when the borrow out of credit minus price is 0.
- R6: change_o is a 3-bit count of nickels owed. While release_o is 1 it equals credit_o - PRICE_UNITS, and while release_o is 0 it is 0. Codes 0 to 5 stand for 0 to 25 cents.
- R7: vend_ack_i high at a clock edge clears the credit to 0 after that edge. This takes priority over an increment that falls due on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_i | input | 1 | Count pulse, one per nickel |
| vend_ack_i | input | 1 | Vend acknowledge, clears credit |
| release_o | output | 1 | Enough credit paid for the product |
| change_o | output | 3 | Change owed in nickels |
| credit_o | output | CREDIT_W | Current credit in nickel units |

## Verification
The assertions assume that pulse_i is synchronous to clk, or has already been synchronised. Each high or low period is assumed to last at least one clock, so no pulse is shorter than the sampling interval. The bench drives pulse_i and vend_ack_i only on falling clock edges. Every pulse it generates stays high and low for whole cycles, and it leaves several idle cycles between pulses. With the default price of ten units the difference never exceeds five, so the 3-bit change code never meets its don't-care range.

// File: rtl/vend_pkg.sv
package vend_pkg;
    localparam int CHG_W = 3;

    typedef enum logic {
        PULSE_IDLE   = 1'b0,
        PULSE_ACTIVE = 1'b1
    } pulse_state_t;
endpackage

// File: rtl/pulse_edge_fsm.sv
module pulse_edge_fsm
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pulse_i,
    output logic inc_o
);
    logic         pulse_q;
    pulse_state_t state_q, state_d;

    // Register the pulse input
    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= pulse_i;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PULSE_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PULSE_IDLE:   if (pulse_q)  state_d = PULSE_ACTIVE; // arm
            PULSE_ACTIVE: if (!pulse_q) state_d = PULSE_IDLE;   // credit
            default:      state_d = PULSE_IDLE;
        endcase
    end

    // Output logic: strobe on trailing edge
    always_comb begin
        inc_o = 1'b0;
        unique case (state_q)
            PULSE_IDLE:   inc_o = 1'b0;
            PULSE_ACTIVE: inc_o = !pulse_q;
            default:      inc_o = 1'b0;
        endcase
    end

    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        inc_o |=> !inc_o);

    assert_strobe_after_high_R2: assert property (@(posedge clk) disable iff (rst)
        inc_o |-> $past(pulse_q));
endmodule

// File: rtl/credit_accum.sv
module credit_accum #(
    parameter int CREDIT_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                inc_i,
    input  logic                clear_i,
    output logic [CREDIT_W-1:0] credit_o
);
    localparam logic [CREDIT_W-1:0] CREDIT_MAX = {CREDIT_W{1'b1}};

    logic [CREDIT_W-1:0] credit_q;
    logic [CREDIT_W-1:0] sum;
    logic                carry;

    // Carry out of the adder signals saturation
    assign {carry, sum} = {1'b0, credit_q} + {{CREDIT_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)                  credit_q <= '0;
        else if (clear_i)         credit_q <= '0;
        else if (inc_i && !carry) credit_q <= sum;
    end

    assign credit_o = credit_q;

    assert_sat_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (credit_q == CREDIT_MAX && !clear_i) |=> credit_q == CREDIT_MAX);

    assert_ack_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> credit_q == '0);

    assert_unit_step_R2: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> (credit_q == $past(credit_q)) ||
                     (credit_q == $past(credit_q) + 1'b1));
endmodule

// File: rtl/borrow_subtractor.sv
module borrow_subtractor #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] diff_o,
    output logic             borrow_o
);
    logic [WIDTH:0] chain;

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic ab_x;
        assign ab_x        = a_i[i] ^ b_i[i];
        assign diff_o[i]   = ab_x ^ chain[i];
        assign chain[i+1]  = (~a_i[i] & b_i[i]) | (~ab_x & chain[i]);
    end

    assign borrow_o = chain[WIDTH];

    assert_borrow_compare_R5: assert property (@(posedge clk) disable iff (rst)
        borrow_o == (a_i < b_i));
endmodule

// File: rtl/change_decode.sv
module change_decode
    import vend_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] diff_i,
    input  logic             borrow_i,
    output logic             release_o,
    output logic [CHG_W-1:0] change_o
);
    // Only the low bits matter: differences above five nickels are don't-care
    always_comb begin
        release_o = !borrow_i;
        change_o  = borrow_i ? '0 : diff_i[CHG_W-1:0];
    end
endmodule

// File: rtl/vend_credit_unit.sv
module vend_credit_unit
    import vend_pkg::*;
#(
    parameter int CREDIT_W    = 4,
    parameter int PRICE_UNITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pulse_i,
    input  logic                vend_ack_i,
    output logic                release_o,
    output logic [CHG_W-1:0]    change_o,
    output logic [CREDIT_W-1:0] credit_o
);
    localparam logic [CREDIT_W-1:0] PRICE = CREDIT_W'(PRICE_UNITS);

    logic                inc;
    logic [CREDIT_W-1:0] credit;
    logic [CREDIT_W-1:0] diff;
    logic                borrow;

    pulse_edge_fsm u_edge (
        .clk     (clk),
        .rst     (rst),
        .pulse_i (pulse_i),
        .inc_o   (inc)
    );

    credit_accum #(.CREDIT_W(CREDIT_W)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .inc_i    (inc),
        .clear_i  (vend_ack_i),
        .credit_o (credit)
    );

    borrow_subtractor #(.WIDTH(CREDIT_W)) u_sub (
        .clk      (clk),
        .rst      (rst),
        .a_i      (credit),
        .b_i      (PRICE),
        .diff_o   (diff),
        .borrow_o (borrow)
    );

    change_decode #(.WIDTH(CREDIT_W)) u_dec (
        .diff_i    (diff),
        .borrow_i  (borrow),
        .release_o (release_o),
        .change_o  (change_o)
    );

    assign credit_o = credit;

    assert_release_enough_R5: assert property (@(posedge clk) disable iff (rst)
        release_o |-> credit_o >= PRICE);

    assert_no_change_held_R6: assert property (@(posedge clk) disable iff (rst)
        !release_o |-> change_o == '0);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (credit_o == '0));
endmodule

// File: tb/vend_credit_unit_tb.sv
module vend_credit_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pulse_i = 1'b0;
    logic       vend_ack_i = 1'b0;
    logic       release_o;
    logic [2:0] change_o;
    logic [3:0] credit_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Fields: ack[12] pulses[11:8] credit[7:4] release[3] change[2:0]
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, 4'd3,  4'd3,  1'b0, 3'd0},
        {1'b0, 4'd6,  4'd9,  1'b0, 3'd0},
        {1'b0, 4'd1,  4'd10, 1'b1, 3'd0},
        {1'b0, 4'd2,  4'd12, 1'b1, 3'd2},
        {1'b0, 4'd3,  4'd15, 1'b1, 3'd5},
        {1'b0, 4'd2,  4'd15, 1'b1, 3'd5},
        {1'b1, 4'd0,  4'd0,  1'b0, 3'd0},
        {1'b0, 4'd11, 4'd11, 1'b1, 3'd1}
    };

    vend_credit_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .pulse_i    (pulse_i),
        .vend_ack_i (vend_ack_i),
        .release_o  (release_o),
        .change_o   (change_o),
        .credit_o   (credit_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic give_pulse(input int high_cycles);
        @(negedge clk) pulse_i = 1'b1;
        repeat (high_cycles) @(negedge clk);
        pulse_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 credit", credit_o, 0);
        chk("R1 release", release_o, 0);
        chk("R1 change", change_o, 0);

        // Vector table: R2 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][12]) begin
                @(negedge clk) vend_ack_i = 1'b1;
                @(negedge clk) vend_ack_i = 1'b0;
            end
            for (int p = 0; p < int'(VEC[v][11:8]); p++) give_pulse(2);
            chk("R2/R4 credit vec", credit_o, int'(VEC[v][7:4]));
            chk("R5 release vec", release_o, int'(VEC[v][3]));
            chk("R6 change vec", change_o, int'(VEC[v][2:0]));
        end

        // R7 plain clear
        @(negedge clk) vend_ack_i = 1'b1;
        @(negedge clk) vend_ack_i = 1'b0;
        chk("R7 clear", credit_o, 0);

        // R3 long pulse: no change while high, one unit total
        @(negedge clk) pulse_i = 1'b1;
        repeat (20) @(negedge clk);
        chk("R3 held high", credit_o, 0);
        pulse_i = 1'b0;
        // R2 exact timing of trailing-edge capture
        @(negedge clk);
        chk("R2 not yet", credit_o, 0);
        @(negedge clk);
        chk("R2 captured", credit_o, 1);
        repeat (5) @(negedge clk);
        chk("R3 once only", credit_o, 1);

        // R7 priority over a same-edge increment
        @(negedge clk) pulse_i = 1'b1;
        repeat (3) @(negedge clk);
        pulse_i = 1'b0;
        @(negedge clk) vend_ack_i = 1'b1;
        @(negedge clk) vend_ack_i = 1'b0;
        chk("R7 priority", credit_o, 0);
        repeat (3) @(negedge clk);
        chk("R7 strobe consumed", credit_o, 0);

        // R1 reset mid-run
        give_pulse(2); give_pulse(2);
        chk("R2 pre-reset", credit_o, 2);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk("R1 mid reset", credit_o, 0);
        chk("R1 mid release", release_o, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule